// File: doc/BRIEF.md
# Partitioned Pixel Pack Unit

This unit converts between partitioned fixed-point lanes and packed pixel bytes for a graphics datapath. Each issued operation carries a 3-bit operation select, two 64-bit operands (A and B) and the 5-bit scale field taken from bits [7:3] of the graphics status register. The unit computes the result in one pass of combinational logic and registers it. `out_valid` is raised for exactly one cycle, one clock after each `in_valid`.

The three pack forms scale a signed lane by a left shift, drop the fraction with an arithmetic right shift, and clamp the value to the range of the destination. The byte pack with shift-in also keeps the earlier pixels of A, moved up one byte. Expand turns pixel bytes into fixed-point lanes. Merge interleaves the bytes of two pixel words. Operand fetch, decode and fault handling belong to the surrounding pipeline.

Top module: `pixel_pack_unit`

## Requirements
- R1: When `in_op`=0 (16-bit byte pack), each signed 16-bit lane k of B is shifted left by the scale, shifted right arithmetically by 7 and clamped to 0..255. The result is placed in byte k of the output. Output bits [63:32] are zero.
- R2: The 16-bit byte pack uses only scale bits [3:0]. Scale bit 4 has no effect on its result.
- R3: When `in_op`=1 (byte pack with shift-in), the output is A shifted left by 8 with bytes 0 and 4 cleared. Each signed 32-bit lane k of B is shifted left by the scale, shifted right arithmetically by 23, clamped to 0..255, and OR-ed into byte 4k.
- R4: When `in_op`=2 (fixed pack), each signed 32-bit lane k of B is shifted left by the scale, shifted right arithmetically by 16 and saturated to -32768..32767. Its low 16 bits go to output bits [16k+15:16k]. Output bits [63:32] are zero.
- R5: When `in_op`=3 (expand), byte k of B[31:0] is shifted left by 4 and placed in 16-bit lane k. Bits [3:0] and [15:12] of each lane are zero.
- R6: When `in_op`=4 (merge), output byte 2k is byte k of B and output byte 2k+1 is byte k of A, for k = 0..3. A[63:32] and B[63:32] are ignored.
- R7: Both 32-bit pack forms use all five scale bits. The scaled intermediate is kept wide, so a scale of 31 loses no bits before the clamp.
- R8: `in_op` values 5, 6 and 7 produce an all-zero result, and `out_valid` is still raised.
- R9: `out_valid` is high in the cycle after each `in_valid` and low otherwise. Operations issued on consecutive cycles each produce their own result on consecutive cycles.
- R10: While `in_valid` is low, `out_data` holds its last value whatever the operands and select do.
- R11: A synchronous reset clears `out_valid` and `out_data` to zero, even if `in_valid` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for one operation |
| in_op | input | 3 | Operation select (0..4 defined, 5..7 yield zero) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| gsr_scale | input | 5 | Scale field, status register bits [7:3] |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 64 | Registered result |

## Verification
The bench issues operations back to back, so a result register loading one operation's value and the unit accepting the next one happen on the same clock edge. In that test a shift-in pack is followed directly by a merge. Each result is sampled in its own cycle and compared with its own expected word, and the output must then hold while idle. A second case places a synchronous reset in the same cycle as an issue strobe, and the reset is expected to win.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
   localparam int LANE16 = 16;
   localparam int LANE32 = 32;

   typedef enum logic [2:0] {
      OP_PACK16  = 3'd0,
      OP_PACK32  = 3'd1,
      OP_PACKFIX = 3'd2,
      OP_EXPAND  = 3'd3,
      OP_MERGE   = 3'd4
   } pxp_op_e;
endpackage

// File: rtl/pxp_lane_pack.sv
// Scale, fraction drop and clamp for one signed lane.
module pxp_lane_pack #(
   parameter int IN_W       = 16,
   parameter int SCALE_W    = 4,
   parameter int FRAC       = 7,
   parameter int OUT_W      = 8,
   parameter bit SIGNED_OUT = 1'b0
) (
   input  logic [IN_W-1:0]    lane_in,
   input  logic [SCALE_W-1:0] scale,
   output logic [OUT_W-1:0]   lane_out
);
   localparam int WIDE = IN_W + (1 << SCALE_W);
   localparam logic signed [WIDE-1:0] HI = SIGNED_OUT ?
      WIDE'((64'sd1 <<< (OUT_W-1)) - 64'sd1) : WIDE'((64'sd1 <<< OUT_W) - 64'sd1);

   if (WIDE > 64) begin : g_bad_wide
      $error("pxp_lane_pack: intermediate wider than 64 bits");
   end
   if (FRAC >= WIDE || OUT_W >= WIDE) begin : g_bad_frac
      $error("pxp_lane_pack: fraction or output width too large");
   end

   logic signed [WIDE-1:0] ext, shl, shr;

   always_comb begin
      ext = {{(WIDE-IN_W){lane_in[IN_W-1]}}, lane_in};
      shl = ext << scale;
      shr = shl >>> FRAC;
   end

   if (SIGNED_OUT) begin : g_sat_signed
      localparam logic signed [WIDE-1:0] LO = ~HI;
      always_comb begin
         if (shr > HI)      lane_out = HI[OUT_W-1:0];
         else if (shr < LO) lane_out = LO[OUT_W-1:0];
         else               lane_out = shr[OUT_W-1:0];
      end
   end else begin : g_sat_unsigned
      always_comb begin
         if (shr[WIDE-1])   lane_out = '0;
         else if (shr > HI) lane_out = HI[OUT_W-1:0];
         else               lane_out = shr[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/pxp_byte_shuffle.sv
// Expand (byte -> 16-bit lane) and byte interleave of two half words.
module pxp_byte_shuffle #(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W/2-1:0] half_a,
   input  logic [DATA_W/2-1:0] half_b,
   output logic [DATA_W-1:0]   expand_out,
   output logic [DATA_W-1:0]   merge_out
);
   localparam int NBYTE = DATA_W / 2 / BYTE_W;
   localparam int PAD   = 4;

   if (2*BYTE_W != pxp_pkg::LANE16 || BYTE_W < 2*PAD) begin : g_bad_byte
      $error("pxp_byte_shuffle: byte width must be half a 16-bit lane");
   end

   for (genvar k = 0; k < NBYTE; k++) begin : g_byte
      assign expand_out[2*BYTE_W*k +: 2*BYTE_W] =
         {{PAD{1'b0}}, half_b[BYTE_W*k +: BYTE_W], {PAD{1'b0}}};
      assign merge_out[2*BYTE_W*k +: 2*BYTE_W] =
         {half_a[BYTE_W*k +: BYTE_W], half_b[BYTE_W*k +: BYTE_W]};
   end
endmodule

// File: rtl/pixel_pack_unit.sv
module pixel_pack_unit
   import pxp_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int BYTE_W  = 8,
   parameter int SCALE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [SCALE_W-1:0] gsr_scale,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int N16       = DATA_W / LANE16;
   localparam int N32       = DATA_W / LANE32;
   localparam int HALF      = DATA_W / 2;
   localparam int LOW_SCL_W = SCALE_W - 1;
   localparam logic [DATA_W-1:0] LOWBYTE_MASK =
      {N32{{(LANE32-BYTE_W){1'b0}}, {BYTE_W{1'b1}}}};

   if (DATA_W % LANE32 != 0 || DATA_W < LANE32) begin : g_bad_dw
      $error("pixel_pack_unit: DATA_W must be a multiple of 32");
   end
   if (SCALE_W < 2) begin : g_bad_scale
      $error("pixel_pack_unit: scale field too narrow");
   end

   logic [BYTE_W-1:0] p16_byte [N16];
   logic [BYTE_W-1:0] p32_byte [N32];
   logic [LANE16-1:0] fix_half [N32];
   logic [DATA_W-1:0] expand_w, merge_w, a_shl, result;

   for (genvar g = 0; g < N16; g++) begin : g_p16
      pxp_lane_pack #(.IN_W(LANE16), .SCALE_W(LOW_SCL_W), .FRAC(7),
                      .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_lane (
         .lane_in (src_b[LANE16*g +: LANE16]),
         .scale   (gsr_scale[LOW_SCL_W-1:0]),
         .lane_out(p16_byte[g])
      );
   end

   for (genvar g = 0; g < N32; g++) begin : g_p32
      pxp_lane_pack #(.IN_W(LANE32), .SCALE_W(SCALE_W), .FRAC(23),
                      .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_pix (
         .lane_in (src_b[LANE32*g +: LANE32]),
         .scale   (gsr_scale),
         .lane_out(p32_byte[g])
      );
      pxp_lane_pack #(.IN_W(LANE32), .SCALE_W(SCALE_W), .FRAC(16),
                      .OUT_W(LANE16), .SIGNED_OUT(1'b1)) u_fix (
         .lane_in (src_b[LANE32*g +: LANE32]),
         .scale   (gsr_scale),
         .lane_out(fix_half[g])
      );
   end

   pxp_byte_shuffle #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shuffle (
      .half_a    (src_a[HALF-1:0]),
      .half_b    (src_b[HALF-1:0]),
      .expand_out(expand_w),
      .merge_out (merge_w)
   );

   assign a_shl = src_a << BYTE_W;

   always_comb begin
      result = '0;
      case (in_op)
         OP_PACK16: begin
            for (int k = 0; k < N16; k++) result[BYTE_W*k +: BYTE_W] = p16_byte[k];
         end
         OP_PACK32: begin
            for (int k = 0; k < N32; k++) result[LANE32*k +: BYTE_W] = p32_byte[k];
            result = result | (a_shl & ~LOWBYTE_MASK);
         end
         OP_PACKFIX: begin
            for (int k = 0; k < N32; k++) result[LANE16*k +: LANE16] = fix_half[k];
         end
         OP_EXPAND: result = expand_w;
         OP_MERGE:  result = merge_w;
         default:   result = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end

   // R11: reset clears the result register
   p_reset_clears_r11: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

   // R9: one strobe out per strobe in, one cycle later
   p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R10: idle cycles keep the result
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));

   // R1: 16-bit byte pack leaves the upper half clear
   p_pack16_upper_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == OP_PACK16) |=> out_data[DATA_W-1:HALF] == '0);

   // R5: expanded lanes have clear low and high nibbles
   p_expand_pad_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == OP_EXPAND) |=>
         (out_data[3:0] == 4'h0 && out_data[LANE16-1 -: 4] == 4'h0));

   // R6: merge puts B's low byte at the bottom
   p_merge_low_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == OP_MERGE) |=>
         out_data[BYTE_W-1:0] == $past(src_b[BYTE_W-1:0]));

   // R8: undefined selects give zero
   p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op > OP_MERGE) |=> out_data == '0);
endmodule

// File: tb/pixel_pack_unit_bench.sv
module pixel_pack_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   typedef struct packed {
      logic [7:0]  req;
      logic [2:0]  op;
      logic [4:0]  scale;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // R1: scale 0, rounding down, negative -> 0, large -> 255
      '{8'd1, 3'd0, 5'd0,  64'h0, 64'h0100_7FFF_FF80_0080, 64'h0000_0000_02FF_0001},
      // R1: scale 3
      '{8'd1, 3'd0, 5'd3,  64'h0, 64'h8000_1000_0020_0010, 64'h0000_0000_00FF_0201},
      // R2: scale 19 behaves as 3
      '{8'd2, 3'd0, 5'd19, 64'h0, 64'h8000_1000_0020_0010, 64'h0000_0000_00FF_0201},
      // R3: shift-in of A, new bytes at 0 and 4
      '{8'd3, 3'd1, 5'd0,  64'h1122_3344_5566_7788, 64'h7FFF_FFFF_0080_0000, 64'h2233_44FF_6677_8801},
      // R7: scale 31 keeps the top bit of a +1 lane
      '{8'd7, 3'd1, 5'd31, 64'h0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_00FF},
      // R4: exact minimum, scale 0
      '{8'd4, 3'd2, 5'd0,  64'h0, 64'h8000_0000_0001_0000, 64'h0000_0000_8000_0001},
      // R4: positive saturation, scale 4
      '{8'd4, 3'd2, 5'd4,  64'h0, 64'h4000_0000_0008_0000, 64'h0000_0000_7FFF_0080},
      // R4: negative value and negative saturation, scale 5
      '{8'd4, 3'd2, 5'd5,  64'h0, 64'hC000_0000_FFF0_0000, 64'h0000_0000_8000_FE00},
      // R5: expand, upper half of B ignored
      '{8'd5, 3'd3, 5'd9,  64'hDEAD_BEEF_0BAD_F00D, 64'hAAAA_AAAA_FF01_807F, 64'h0FF0_0010_0800_07F0},
      // R6: merge, upper halves ignored
      '{8'd6, 3'd4, 5'd0,  64'hFFFF_FFFF_A3A2_A1A0, 64'h1234_5678_B3B2_B1B0, 64'hA3B3_A2B2_A1B1_A0B0},
      // R8: select 5
      '{8'd8, 3'd5, 5'd3,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
      // R8: select 7
      '{8'd8, 3'd7, 5'd0,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [63:0] src_a = '0, src_b = '0;
   logic [4:0]  gsr_scale = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixel_pack_unit u_pixel_pack_unit (
      .clk, .rst, .in_valid, .in_op, .src_a, .src_b, .gsr_scale,
      .out_valid, .out_data
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [4:0] scl,
                        input logic [63:0] a, input logic [63:0] b);
      in_valid  = 1'b1;
      in_op     = op;
      gsr_scale = scl;
      src_a     = a;
      src_b     = b;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 valid", {63'h0, out_valid}, 64'h0);
      chk("R11 data", out_data, 64'h0);
      rst = 1'b0;

      // R9: one operation per vector, result one cycle later
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i].op, VECS[i].scale, VECS[i].a, VECS[i].b);
         @(negedge clk);
         in_valid = 1'b0;
         chk($sformatf("R%0d vector %0d", VECS[i].req, i), out_data, VECS[i].exp);
         chk("R9 valid", {63'h0, out_valid}, 64'h1);
      end

      // R10: idle cycles with changing inputs leave the result alone
      @(negedge clk);
      drive(3'd4, 5'd0, 64'h0000_0000_4433_2211, 64'h0000_0000_8877_6655);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 setup", out_data, 64'h4488_3377_2266_1155);
      for (int j = 0; j < 3; j++) begin
         in_op = 3'(j); src_a = {16{4'(j + 3)}}; src_b = ~src_a; gsr_scale = 5'(j);
         @(negedge clk);
         chk("R10 hold", out_data, 64'h4488_3377_2266_1155);
         chk("R9 idle", {63'h0, out_valid}, 64'h0);
      end

      // R9: back to back issue, shift-in pack then merge
      @(negedge clk);
      drive(3'd1, 5'd0, 64'h0000_0001_0000_0002, 64'h0100_0000_0200_0000);
      @(negedge clk);
      chk("R3 back-to-back first", out_data, 64'h0000_0102_0000_0204);
      chk("R9 first valid", {63'h0, out_valid}, 64'h1);
      drive(3'd4, 5'd0, 64'h0000_0000_0000_00CC, 64'h0000_0000_0000_00DD);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 back-to-back second", out_data, 64'h0000_0000_0000_CCDD);
      chk("R9 second valid", {63'h0, out_valid}, 64'h1);
      @(negedge clk);
      chk("R9 trailing idle", {63'h0, out_valid}, 64'h0);

      // R11: reset wins over an issue in the same cycle
      drive(3'd3, 5'd0, 64'h0, 64'h0000_0000_1111_1111);
      rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b0;
      chk("R11 mid-run valid", {63'h0, out_valid}, 64'h0);
      chk("R11 mid-run data", out_data, 64'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule